// File: doc/BRIEF.md
# Hysteresis-Qualified Trigger Selector

This block decides when a two-channel sampler should start its capture. It watches two signed sample streams that share one valid strobe, and two asynchronous external trigger lines. A 3-bit source code picks one of seven trigger conditions, and the block answers with a trigger pulse one clock cycle wide. The conditions are an immediate trigger, a rising or falling level crossing on either channel, and a rising edge on either external line. Arming, capture control and sample storage are handled elsewhere.

Each channel has a signed level and an unsigned hysteresis width. A crossing counts only after the signal has first moved clear of the level by more than the hysteresis on the far side, so noise sitting on the level cannot retrigger. All four crossing detectors (two channels, two directions) run all the time. The source code only chooses which detector's result reaches the output.

Each crossing detector is a two-state machine. In `DET_IDLE` it moves to `DET_PRIMED` when a valid sample lies beyond the hysteresis band. In `DET_PRIMED` it fires and returns to `DET_IDLE` when a valid sample reaches the level. The output stage is also a two-state machine. `OUT_QUIET` moves to `OUT_PULSE` when the selected source requests a pulse. `OUT_PULSE` always returns to `OUT_QUIET` on the next cycle.

Top module: `trig_hyst_detect`

## Requirements
- R1: After reset, `trig_o` is 0 and stays 0 until a selected source requests a pulse.
- R2: With `src_sel` = 0, `trig_o` never pulses, whatever the samples or external lines do.
- R3: When `src_sel` changes to 1 (immediate), `trig_o` pulses once, one cycle after the first clock edge that samples code 1. Holding code 1 gives no further pulses. Leaving code 1 and returning to it gives a new pulse.
- R4: Code 2 (channel A rising): a valid sample with sample >= level fires, but only if an earlier valid sample was strictly below level − hysteresis. The pulse appears on `trig_o` two edges after the edge that samples the crossing sample.
- R5: Code 3 (channel A falling): a valid sample with sample <= level fires, but only if an earlier valid sample was strictly above level + hysteresis. The latency is the same as in R4.
- R6: Codes 4 and 5 apply R4 and R5 to channel B, with channel B's own level and hysteresis.
- R7: Hysteresis: after a firing, no further firing occurs until the signal again leaves the band. A sample exactly at level − hysteresis (rising) or at level + hysteresis (falling) does not prime. The band may reach past the 14-bit range without wrapping.
- R8: Codes 6 and 7 select external line 0 and external line 1. A rising edge pulses `trig_o` three edges after the edge that first samples the line high. A line held high gives only one pulse.
- R9: Every pulse on `trig_o` lasts exactly one clock cycle.
- R10: Samples and levels are compared as signed 14-bit two's-complement values. The hysteresis is unsigned.
- R11: Activity on sources that are not selected never produces a pulse.
- R12: Samples presented while `smp_vld` is 0 neither prime nor fire a detector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| src_sel | input | 3 | Trigger source code (0 none, 1 immediate, 2/3 A rise/fall, 4/5 B rise/fall, 6/7 external 0/1) |
| smp_vld | input | 1 | Both channel samples are valid this cycle |
| a_smp | input | 14 | Channel A sample, signed |
| b_smp | input | 14 | Channel B sample, signed |
| a_level | input | 14 | Channel A trigger level, signed |
| a_hyst | input | 14 | Channel A hysteresis, unsigned |
| b_level | input | 14 | Channel B trigger level, signed |
| b_hyst | input | 14 | Channel B hysteresis, unsigned |
| ext_trig | input | 2 | Asynchronous external trigger lines |
| trig_o | output | 1 | One-cycle trigger pulse |

## Verification
The hardest situation to reach is a detector state that depends on earlier history. The detectors keep running while deselected, so whether a crossing fires depends on every earlier valid sample, not only on the current selection. The stimulus therefore puts a channel into a known state before each test. With the source set to none, it drives full-scale positive, full-scale negative and then mid samples; this leaves the rising detector primed and the falling detector idle. Only after that does it select the source and walk the samples through the boundary values: exactly at the band edge, exactly at the level, negative levels, and a band that extends past the 14-bit range.

// File: rtl/trig_pkg.sv
package trig_pkg;

    typedef enum logic [2:0] {
        SRC_NONE = 3'd0,
        SRC_NOW  = 3'd1,
        SRC_A_UP = 3'd2,
        SRC_A_DN = 3'd3,
        SRC_B_UP = 3'd4,
        SRC_B_DN = 3'd5,
        SRC_EXT0 = 3'd6,
        SRC_EXT1 = 3'd7
    } src_e;

    typedef enum logic {
        DET_IDLE   = 1'b0,
        DET_PRIMED = 1'b1
    } det_state_e;

    typedef enum logic {
        OUT_QUIET = 1'b0,
        OUT_PULSE = 1'b1
    } out_state_e;

endpackage

// File: rtl/trig_cross_det.sv
module trig_cross_det
    import trig_pkg::*;
#(
    parameter int W       = 14,
    parameter bit FALLING = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         smp_vld,
    input  logic [W-1:0] smp,
    input  logic [W-1:0] level,
    input  logic [W-1:0] hyst,
    output logic         fire_o
);
    localparam int EW = W + 2;

    det_state_e state_q, state_d;
    logic signed [EW-1:0] smp_x, lvl_x, hyst_x, bound;
    logic prime_cond, hit_cond;

    assign smp_x  = {{2{smp[W-1]}}, smp};
    assign lvl_x  = {{2{level[W-1]}}, level};
    assign hyst_x = {2'b00, hyst};

    generate
        if (FALLING) begin : g_fall
            assign bound      = lvl_x + hyst_x;
            assign prime_cond = smp_x > bound;
            assign hit_cond   = smp_x <= lvl_x;
        end else begin : g_rise
            assign bound      = lvl_x - hyst_x;
            assign prime_cond = smp_x < bound;
            assign hit_cond   = smp_x >= lvl_x;
        end
    endgenerate

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DET_IDLE:   if (smp_vld && prime_cond) state_d = DET_PRIMED;
            DET_PRIMED: if (smp_vld && hit_cond)   state_d = DET_IDLE;
            default:    state_d = DET_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DET_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fire_o <= 1'b0;
        else        fire_o <= (state_q == DET_PRIMED) && smp_vld && hit_cond;
    end

endmodule

// File: rtl/trig_ext_edge.sv
module trig_ext_edge #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    logic [SYNC:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[SYNC-1:0], async_i};
    end

    assign rise_o = pipe_q[SYNC-1] & ~pipe_q[SYNC];

endmodule

// File: rtl/trig_hyst_detect.sv
module trig_hyst_detect
    import trig_pkg::*;
#(
    parameter int W    = 14,
    parameter int SYNC = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [2:0]   src_sel,
    input  logic         smp_vld,
    input  logic [W-1:0] a_smp,
    input  logic [W-1:0] b_smp,
    input  logic [W-1:0] a_level,
    input  logic [W-1:0] a_hyst,
    input  logic [W-1:0] b_level,
    input  logic [W-1:0] b_hyst,
    input  logic [1:0]   ext_trig,
    output logic         trig_o
);
    localparam int N_CH  = 2;
    localparam int N_DIR = 2;
    localparam int N_DET = N_CH * N_DIR;
    localparam int N_EXT = 2;

    logic [W-1:0] ch_smp  [N_CH];
    logic [W-1:0] ch_lvl  [N_CH];
    logic [W-1:0] ch_hyst [N_CH];
    logic [N_DET-1:0] cross_fire;
    logic [N_EXT-1:0] ext_rise;

    assign ch_smp[0]  = a_smp;
    assign ch_smp[1]  = b_smp;
    assign ch_lvl[0]  = a_level;
    assign ch_lvl[1]  = b_level;
    assign ch_hyst[0] = a_hyst;
    assign ch_hyst[1] = b_hyst;

    // detector index = channel*2 + direction (0 rising, 1 falling),
    // matching source codes 2..5 minus two
    generate
        for (genvar c = 0; c < N_CH; c++) begin : g_ch
            for (genvar d = 0; d < N_DIR; d++) begin : g_dir
                trig_cross_det #(.W(W), .FALLING(d == 1)) u_det (
                    .clk     (clk),
                    .rst_n   (rst_n),
                    .smp_vld (smp_vld),
                    .smp     (ch_smp[c]),
                    .level   (ch_lvl[c]),
                    .hyst    (ch_hyst[c]),
                    .fire_o  (cross_fire[c*N_DIR+d])
                );
            end
        end
        for (genvar e = 0; e < N_EXT; e++) begin : g_ext
            trig_ext_edge #(.SYNC(SYNC)) u_edge (
                .clk     (clk),
                .rst_n   (rst_n),
                .async_i (ext_trig[e]),
                .rise_o  (ext_rise[e])
            );
        end
    endgenerate

    // immediate source: request on entry to code 1
    logic now_prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) now_prev_q <= 1'b0;
        else        now_prev_q <= (src_sel == SRC_NOW);
    end

    logic sel_req;
    always_comb begin
        unique case (src_e'(src_sel))
            SRC_NONE: sel_req = 1'b0;
            SRC_NOW:  sel_req = ~now_prev_q;
            SRC_A_UP: sel_req = cross_fire[0];
            SRC_A_DN: sel_req = cross_fire[1];
            SRC_B_UP: sel_req = cross_fire[2];
            SRC_B_DN: sel_req = cross_fire[3];
            SRC_EXT0: sel_req = ext_rise[0];
            SRC_EXT1: sel_req = ext_rise[1];
            default:  sel_req = 1'b0;
        endcase
    end

    out_state_e out_q, out_d;
    always_comb begin
        out_d = out_q;
        unique case (out_q)
            OUT_QUIET: if (sel_req) out_d = OUT_PULSE;
            OUT_PULSE: out_d = OUT_QUIET;
            default:   out_d = OUT_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= OUT_QUIET;
        else        out_q <= out_d;
    end

    always_comb trig_o = (out_q == OUT_PULSE);

endmodule

// File: rtl/trig_hyst_detect_chk.sv
module trig_hyst_detect_chk #(
    parameter int W = 14
) (
    input logic         clk,
    input logic         rst_n,
    input logic [2:0]   src_sel,
    input logic         smp_vld,
    input logic [W-1:0] a_smp,
    input logic [W-1:0] a_level,
    input logic [1:0]   ext_trig,
    input logic         trig_o
);
    p_no_pulse_none_r2: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> $past(src_sel) != 3'd0);

    p_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |=> !trig_o);

    p_now_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_o && $past(src_sel) == 3'd1 && $past(rst_n, 2)) |-> $past(src_sel, 2) != 3'd1);

    p_a_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_o && $past(src_sel) == 3'd2) |->
        ($past(smp_vld, 2) && $signed($past(a_smp, 2)) >= $signed($past(a_level, 2))));

    p_a_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_o && $past(src_sel) == 3'd3) |->
        ($past(smp_vld, 2) && $signed($past(a_smp, 2)) <= $signed($past(a_level, 2))));

    p_ext0_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_o && $past(src_sel) == 3'd6) |-> $past(ext_trig[0], 3));

endmodule

bind trig_hyst_detect trig_hyst_detect_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_sel  (src_sel),
    .smp_vld  (smp_vld),
    .a_smp    (a_smp),
    .a_level  (a_level),
    .ext_trig (ext_trig),
    .trig_o   (trig_o)
);

// File: tb/tb_trig_hyst_detect.sv
module tb_trig_hyst_detect;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  src_sel = 3'd0;
    logic        smp_vld = 1'b0;
    logic [13:0] a_smp = '0, b_smp = '0;
    logic [13:0] a_level = '0, a_hyst = '0, b_level = '0, b_hyst = '0;
    logic [1:0]  ext_trig = 2'b00;
    logic        trig_o;

    trig_hyst_detect dut (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .smp_vld(smp_vld),
        .a_smp(a_smp), .b_smp(b_smp), .a_level(a_level), .a_hyst(a_hyst),
        .b_level(b_level), .b_hyst(b_hyst), .ext_trig(ext_trig), .trig_o(trig_o)
    );

    always #5 clk = ~clk;

    typedef struct { int cyc; string tag; } exp_t;
    exp_t  q[$];
    int    cyc = 0;
    int    n_chk = 0;
    int    n_err = 0;
    bit    done = 1'b0;
    string cur_tag = "R1";
    logic  exp_now;
    string tag_now;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compare trig_o against the scoreboard every cycle
    always @(negedge clk) begin
        if (!done && cyc > 0) begin
            exp_now = (q.size() > 0) && (q[0].cyc == cyc);
            tag_now = exp_now ? q[0].tag : cur_tag;
            n_chk++;
            if (trig_o !== exp_now) begin
                n_err++;
                $display("FAIL %s cycle %0d trig_o=%b expected %b", tag_now, cyc, trig_o, exp_now);
            end
            if (exp_now) void'(q.pop_front());
        end
    end

    task automatic push(input int lat);
        exp_t e;
        e.cyc = cyc + lat;
        e.tag = cur_tag;
        q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_sel(input int v);
        @(negedge clk);
        if (v == 1 && src_sel != 3'd1) push(1);
        src_sel = 3'(v);
        @(negedge clk);
    endtask

    // one valid (or invalid) sample on a channel, then valid drops
    task automatic drive(input int ch, input int v, input bit vld, input bit exp);
        @(negedge clk);
        if (ch == 0) a_smp = 14'(v); else b_smp = 14'(v);
        smp_vld = vld;
        if (exp) push(2);
        @(negedge clk);
        smp_vld = 1'b0;
    endtask

    // leaves rising detector primed, falling detector idle
    task automatic quiet(input int ch);
        set_sel(0);
        drive(ch, 8191, 1, 0);
        drive(ch, -8192, 1, 0);
        drive(ch, 0, 1, 0);
        idle(3);
    endtask

    initial begin
        idle(4);
        cur_tag = "R1";
        rst_n = 1'b1;
        idle(4);

        // R2: no source selected
        cur_tag = "R2";
        a_level = 14'(100); a_hyst = 14'(20);
        b_level = 14'(1000); b_hyst = 14'(0);
        drive(0, -500, 1, 0); drive(0, 500, 1, 0);
        drive(1, -500, 1, 0); drive(1, 1500, 1, 0);
        @(negedge clk) ext_trig = 2'b11;
        idle(6);
        @(negedge clk) ext_trig = 2'b00;
        idle(4);

        // R3: immediate
        cur_tag = "R3";
        set_sel(1); idle(6);
        set_sel(0); idle(2);
        set_sel(1); idle(4);

        // R4 / R7: channel A rising
        quiet(0);
        cur_tag = "R4";
        set_sel(2);
        drive(0, 100, 1, 1);
        cur_tag = "R7";
        drive(0, 120, 1, 0);
        drive(0, 90, 1, 0);
        drive(0, 110, 1, 0);
        drive(0, 80, 1, 0);
        drive(0, 100, 1, 0);
        cur_tag = "R4";
        drive(0, 79, 1, 0);
        drive(0, 100, 1, 1);

        // R10: negative level
        cur_tag = "R10";
        a_level = 14'(-50); a_hyst = 14'(10);
        drive(0, -55, 1, 0);
        drive(0, -40, 1, 0);
        drive(0, -61, 1, 0);
        drive(0, -50, 1, 1);

        // R12: invalid samples ignored
        cur_tag = "R12";
        drive(0, -100, 0, 0);
        drive(0, 0, 1, 0);
        drive(0, -100, 1, 0);
        drive(0, 0, 0, 0);
        drive(0, 0, 1, 1);

        // R7: band beyond 14-bit range never primes
        cur_tag = "R7";
        a_level = 14'(-8192); a_hyst = 14'(16383);
        drive(0, -8192, 1, 0);
        drive(0, 8191, 1, 0);
        drive(0, -8192, 1, 0);
        idle(3);

        // R5: channel A falling
        a_level = 14'(100); a_hyst = 14'(20);
        quiet(0);
        cur_tag = "R5";
        set_sel(3);
        drive(0, 110, 1, 0);
        drive(0, 121, 1, 0);
        drive(0, 101, 1, 0);
        drive(0, 100, 1, 1);
        cur_tag = "R7";
        drive(0, 50, 1, 0);
        drive(0, 120, 1, 0);
        drive(0, 50, 1, 0);
        cur_tag = "R5";
        drive(0, 200, 1, 0);
        drive(0, -3000, 1, 1);

        // R6 / R11: channel B rising, channel A activity ignored
        quiet(1);
        cur_tag = "R6";
        set_sel(4);
        drive(1, 1000, 1, 1);
        drive(1, 999, 1, 0);
        cur_tag = "R11";
        drive(0, -8192, 1, 0);
        drive(0, 8191, 1, 0);
        drive(0, -8192, 1, 0);
        cur_tag = "R6";
        drive(1, 1001, 1, 1);

        // R6: channel B falling
        quiet(1);
        set_sel(5);
        drive(1, 1001, 1, 0);
        drive(1, 1000, 1, 1);

        // R8 / R11: external lines
        cur_tag = "R8";
        set_sel(6);
        @(negedge clk) begin ext_trig[0] = 1'b1; push(3); end
        idle(8);
        cur_tag = "R11";
        @(negedge clk) ext_trig[1] = 1'b1;
        idle(5);
        @(negedge clk) begin ext_trig = 2'b00; end
        idle(4);
        cur_tag = "R8";
        set_sel(7);
        @(negedge clk) begin ext_trig[1] = 1'b1; push(3); end
        idle(8);
        cur_tag = "R11";
        @(negedge clk) ext_trig[0] = 1'b0;
        @(negedge clk) ext_trig[0] = 1'b1;
        idle(5);
        cur_tag = "R9";
        set_sel(0);
        idle(5);

        done = 1'b1;
        n_chk++;
        if (q.size() != 0) begin
            n_err++;
            $display("FAIL %s pending expected pulses=%0d expected 0", q[0].tag, q.size());
        end
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    always @(posedge clk) begin
        if (!done && cyc > 20000) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog cycle=%0d expected finish", cyc);
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule